// File: doc/BRIEF.md
# Joystick Axis Pulse-Width Digitizer

This block turns the four one-shot outputs of a joystick front end into 16-bit position counts. Each axis arrives as a digital level that stays high while its timing capacitor is still charging. When a measurement starts, the block clears one counter per enabled axis. Each counter advances on a prescaled clock tick for as long as its axis input stays high. When the measurement ends, the block copies the counts of the enabled axes into read-back latches and raises a ready flag. The ready flag can drive a level interrupt.

Software reaches the block through a byte-wide register window with five offsets. Offset 0 gives a raw view of the buttons and axis levels. Offset 1 holds the axis configuration: axis enables, read-back select, continuous latching and the ready flag. Offsets 2 and 3 return the low and high byte of the selected axis count. Offset 4 holds the hardware configuration: interrupt enable, prescaler and legacy-alias enable. Writing offset 0, 2 or 3 starts a measurement. Button inputs are passed straight through to an output.

A three-state controller sequences each measurement. ST_IDLE waits for work. LAUNCH goes to ST_MEASURE on a software trigger, or when continuous latching is on. In ST_MEASURE the counters run. RESTART stays in ST_MEASURE on a new trigger. SETTLE goes to ST_CAPTURE once every enabled axis has fallen or the timeout expires. ST_CAPTURE lasts one cycle, in which the latches load and the ready flag sets. From there, RELATCH returns to ST_MEASURE on a trigger or in continuous mode, and PARK returns to ST_IDLE otherwise.

Top module: `joy_axis_digitizer`

## Requirements
- R1: After reset, irq and legacy_en are 0, offsets 1 and 4 read 0x00, and every axis latch reads 0.
- R2: Configuration bits 3:0 enable axes 1 to 4. The latch of a disabled axis keeps its value across a measurement, even when that axis input pulses.
- R3: Configuration bits 5:4 select the axis shown at offsets 2 and 3: 00 selects axis 1, 01 axis 2, 10 axis 3 and 11 axis 4. Offset 2 returns count bits 7:0 and offset 3 returns bits 15:8.
- R4: An enabled axis counter starts from zero at measurement start and adds one on each prescaler tick while its input is high. It stops for good when that input falls. At full rate, an input held high for N clock edges after the trigger edge gives a count of N.
- R5: Hardware configuration bits 2:1 select the tick rate: 00 gives one tick per clock, 10 one per 2 clocks, 01 one per 20 clocks and 11 one per 200 clocks. An input held high N edges gives floor(N/divisor).
- R6: A counter that reaches 0xFFFF holds that value and does not wrap.
- R7: A measurement ends when every enabled axis has fallen, or after TIMEOUT_CYC cycles in ST_MEASURE, whichever comes first.
- R8: Writing any value to offset 0, 2 or 3 starts a new measurement of the enabled axes.
- R9: Configuration bit 7 is a read-only ready flag. It sets when a measurement completes and clears when offset 1 is read. A completion in the same cycle as the read wins.
- R10: irq is high exactly while the ready flag is set and hardware configuration bit 0 is 1.
- R11: With configuration bit 6 set, each completed measurement reloads the latches and a new one starts at once, with no trigger needed. With bit 6 clear, no measurement starts unless triggered, so the latches hold while the axis inputs move.
- R12: Hardware configuration bit 3 drives legacy_en. Bits 7:4 of offset 4 always read 0.
- R13: Offset 0 reads the buttons in bits 7:4 and the live axis inputs in bits 3:0. button_out always equals button_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect: ready clear) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| axis_in | input | 4 | One-shot levels, bit 0 is axis 1 |
| button_in | input | 4 | Button levels |
| button_out | output | 4 | Buttons passed through |
| irq | output | 1 | Level interrupt |
| legacy_en | output | 1 | Legacy-address alias enable |

## Verification
The four axes are released at different edges (5, 9, 13 and 17). This shows that each counter stops on its own input and that the read-back select reaches the right latch. The same kind of pulse is then repeated at every prescaler setting. Those runs separate the divisor decoding from the counting and expose any off-by-one in tick placement. One pulse is longer than the timeout. It shows that the counter saturates rather than wraps, and that a measurement ends without all axes falling. Pulses on a disabled axis, and pulses with no trigger while continuous mode is off, show that the latches hold. Continuous mode is checked by a ready flag that reappears without any register write.

// File: rtl/joy_pkg.sv
package joy_pkg;
    localparam int NUM_AXES = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_CAPTURE = 2'd2
    } meas_state_e;

    localparam logic [2:0] ADDR_LEGACY = 3'd0;
    localparam logic [2:0] ADDR_CFG    = 3'd1;
    localparam logic [2:0] ADDR_VAL_LO = 3'd2;
    localparam logic [2:0] ADDR_VAL_HI = 3'd3;
    localparam logic [2:0] ADDR_HWCFG  = 3'd4;

    localparam int DIV_HALF  = 2;
    localparam int DIV_SLOW  = 20;
    localparam int DIV_CRAWL = 200;
endpackage

// File: rtl/joy_prescaler.sv
module joy_prescaler
    import joy_pkg::*;
#(
    parameter int PW = $clog2(DIV_CRAWL)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    always_comb begin
        unique case (div_sel)
            2'b00:   limit = '0;
            2'b10:   limit = PW'(DIV_HALF - 1);
            2'b01:   limit = PW'(DIV_SLOW - 1);
            default: limit = PW'(DIV_CRAWL - 1);
        endcase
    end

    assign tick = run && (pcnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= (pcnt == limit) ? '0 : pcnt + 1'b1;
        end
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != 2'b00) |=> !tick);
endmodule

// File: rtl/joy_axis_counter.sv
module joy_axis_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic          tick,
    input  logic          enable,
    input  logic          axis_in,
    output logic [CW-1:0] count,
    output logic          active
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            active <= 1'b0;
        end else if (start) begin
            count  <= '0;
            active <= enable;
        end else if (run && active) begin
            if (axis_in) begin
                if (tick && count != CNT_MAX) count <= count + 1'b1;
            end else begin
                active <= 1'b0;
            end
        end
    end

    // R6
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !start) |=> count == CNT_MAX);

    // R4
    cnt_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !active) |=> $stable(count));
endmodule

// File: rtl/joy_regs.sv
module joy_regs
    import joy_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [2:0]                 bus_addr,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    input  logic [NUM_AXES-1:0]        axis_in,
    input  logic [3:0]                 button_in,
    input  logic                       capture,
    input  logic [NUM_AXES-1:0][CW-1:0] counts,
    output logic                       trigger,
    output logic [NUM_AXES-1:0]        axis_en,
    output logic                       latch_en,
    output logic [1:0]                 div_sel,
    output logic                       irq,
    output logic                       legacy_en
);
    logic [6:0]                  cfg_q;
    logic [3:0]                  hw_q;
    logic                        ready_q;
    logic [NUM_AXES-1:0][CW-1:0] latch_q;
    logic [15:0]                 sel_val;
    logic                        cfg_read;

    assign axis_en   = cfg_q[3:0];
    assign latch_en  = cfg_q[6];
    assign div_sel   = hw_q[2:1];
    assign legacy_en = hw_q[3];
    assign irq       = ready_q & hw_q[0];
    assign cfg_read  = bus_rd && (bus_addr == ADDR_CFG);
    assign trigger   = bus_wr && (bus_addr == ADDR_LEGACY ||
                                  bus_addr == ADDR_VAL_LO ||
                                  bus_addr == ADDR_VAL_HI);
    assign sel_val   = 16'(latch_q[cfg_q[5:4]]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            hw_q    <= '0;
            ready_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_CFG)   cfg_q <= bus_wdata[6:0];
            if (bus_wr && bus_addr == ADDR_HWCFG) hw_q  <= bus_wdata[3:0];
            if (capture)       ready_q <= 1'b1;
            else if (cfg_read) ready_q <= 1'b0;
        end
    end

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_latch
            always_ff @(posedge clk) begin
                if (!rst_n)                      latch_q[a] <= '0;
                else if (capture && axis_en[a])  latch_q[a] <= counts[a];
            end
        end
    endgenerate

    always_comb begin
        unique case (bus_addr)
            ADDR_LEGACY: bus_rdata = {button_in, axis_in};
            ADDR_CFG:    bus_rdata = {ready_q, cfg_q};
            ADDR_VAL_LO: bus_rdata = sel_val[7:0];
            ADDR_VAL_HI: bus_rdata = sel_val[15:8];
            ADDR_HWCFG:  bus_rdata = {4'b0000, hw_q};
            default:     bus_rdata = 8'h00;
        endcase
    end

    // R9
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ready_q);

    // R9
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_read && !capture) |=> !ready_q);

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(latch_q));
endmodule

// File: rtl/joy_axis_digitizer.sv
module joy_axis_digitizer
    import joy_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TIMEOUT_CYC = 70000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [3:0] axis_in,
    input  logic [3:0] button_in,
    output logic [3:0] button_out,
    output logic       irq,
    output logic       legacy_en
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    meas_state_e state_q, state_d;
    logic [TW-1:0] tcnt_q;
    logic start, run, capture, tick, done, timed_out, trigger, latch_en;
    logic [NUM_AXES-1:0] axis_en, active;
    logic [1:0] div_sel;
    logic [NUM_AXES-1:0][CNT_W-1:0] counts;

    assign button_out = button_in;
    assign timed_out  = (tcnt_q == T_LAST);
    assign done       = ~|active || timed_out;

    joy_regs #(.CW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .axis_in(axis_in), .button_in(button_in), .capture(capture),
        .counts(counts), .trigger(trigger), .axis_en(axis_en),
        .latch_en(latch_en), .div_sel(div_sel), .irq(irq),
        .legacy_en(legacy_en)
    );

    joy_prescaler u_presc (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run),
        .div_sel(div_sel), .tick(tick)
    );

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            joy_axis_counter #(.CW(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .start(start), .run(run),
                .tick(tick), .enable(axis_en[a]), .axis_in(axis_in[a]),
                .count(counts[a]), .active(active[a])
            );
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trigger || latch_en) state_d = ST_MEASURE;  // LAUNCH
            ST_MEASURE: if (trigger)             state_d = ST_MEASURE;  // RESTART
                        else if (done)           state_d = ST_CAPTURE;  // SETTLE
            ST_CAPTURE: if (trigger || latch_en) state_d = ST_MEASURE;  // RELATCH
                        else                     state_d = ST_IDLE;     // PARK
            default:                             state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        start   = 1'b0;
        run     = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE:    start = trigger || latch_en;
            ST_MEASURE: begin
                run   = 1'b1;
                start = trigger;
            end
            ST_CAPTURE: begin
                capture = 1'b1;
                start   = trigger || latch_en;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) tcnt_q <= '0;
        else if (run && !timed_out) tcnt_q <= tcnt_q + 1'b1;
    end

    // R9
    capture_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CAPTURE |=> state_q != ST_CAPTURE);

    // R7
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MEASURE |-> tcnt_q <= T_LAST);

    // R7
    settle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !trigger && (~|active || timed_out))
            |=> state_q == ST_CAPTURE);
endmodule

// File: tb/joy_axis_digitizer_bench.sv
module joy_axis_digitizer_bench;
    import joy_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 70000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] axis_in = '0, button_in = '0, button_out;
    logic irq, legacy_en;

    int errs = 0;
    int checks = 0;
    logic [7:0] cfg_base = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    joy_axis_digitizer #(.TIMEOUT_CYC(TMO)) u_joy_axis_digitizer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .axis_in(axis_in), .button_in(button_in), .button_out(button_out),
        .irq(irq), .legacy_en(legacy_en)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] v);
        cfg_base = v;
        wr(ADDR_CFG, v);
    endtask

    task automatic read_axis(input int i, output int v);
        logic [7:0] lo, hi;
        wr(ADDR_CFG, (cfg_base & 8'h4F) | 8'(i << 4));
        rd(ADDR_VAL_LO, lo);
        rd(ADDR_VAL_HI, hi);
        v = {hi, lo};
    endtask

    // raise axes, trigger via taddr, drop axis i after n[i] edges
    task automatic pulse(input int n0, input int n1, input int n2, input int n3,
                         input logic [2:0] taddr);
        int n[4];
        int mx;
        n[0] = n0; n[1] = n1; n[2] = n2; n[3] = n3;
        mx = 0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            axis_in[i] = (n[i] > 0);
            if (n[i] > mx) mx = n[i];
        end
        wr(taddr, 8'h5A);
        for (int k = 1; k <= mx; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (n[i] == k) axis_in[i] = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        int v;
        chk(irq, 0, "R1 irq after reset");
        chk(legacy_en, 0, "R1 legacy_en after reset");
        rd(ADDR_CFG, d);   chk(d, 0, "R1 cfg after reset");
        rd(ADDR_HWCFG, d); chk(d, 0, "R1 hwcfg after reset");
        read_axis(2, v);   chk(v, 0, "R1 latch after reset");
    endtask

    task automatic t_four_axes;
        logic [7:0] d;
        int v;
        set_cfg(8'h0F);
        wr(ADDR_HWCFG, 8'h01);
        pulse(5, 9, 13, 17, ADDR_VAL_LO);
        repeat (8) @(negedge clk);
        chk(irq, 1, "R10 R7 irq after all axes fell");
        read_axis(0, v); chk(v, 5,  "R4 R8 axis1 count");
        read_axis(1, v); chk(v, 9,  "R3 axis2 count");
        read_axis(2, v); chk(v, 13, "R3 axis3 count");
        read_axis(3, v); chk(v, 17, "R3 axis4 count");
        rd(ADDR_CFG, d); chk(d[7], 1, "R9 ready set");
        rd(ADDR_CFG, d); chk(d[7], 0, "R9 ready cleared by read");
        chk(irq, 0, "R10 irq low after clear");
    endtask

    task automatic t_half_disabled;
        logic [7:0] d;
        int v;
        set_cfg(8'h01);
        wr(ADDR_HWCFG, 8'h05);
        pulse(31, 30, 0, 0, ADDR_VAL_HI);
        repeat (8) @(negedge clk);
        read_axis(0, v); chk(v, 15, "R5 divide by 2");
        read_axis(1, v); chk(v, 9,  "R2 disabled axis latch held");
        rd(ADDR_CFG, d);
    endtask

    task automatic t_slow_rates;
        logic [7:0] d;
        int v;
        wr(ADDR_HWCFG, 8'h03);
        pulse(100, 0, 0, 0, ADDR_LEGACY);
        repeat (8) @(negedge clk);
        read_axis(0, v); chk(v, 5, "R5 R8 divide by 20");
        rd(ADDR_CFG, d);
        wr(ADDR_HWCFG, 8'h06);
        pulse(650, 0, 0, 0, ADDR_VAL_LO);
        repeat (8) @(negedge clk);
        chk(irq, 0, "R10 irq masked");
        read_axis(0, v); chk(v, 3, "R5 divide by 200");
        rd(ADDR_CFG, d); chk(d[7], 1, "R9 ready without irq enable");
    endtask

    task automatic t_hw_legacy;
        logic [7:0] d;
        wr(ADDR_HWCFG, 8'hFF);
        rd(ADDR_HWCFG, d); chk(d, 8'h0F, "R12 hwcfg upper bits zero");
        chk(legacy_en, 1, "R12 legacy_en set");
        wr(ADDR_HWCFG, 8'h01);
        chk(legacy_en, 0, "R12 legacy_en clear");
        button_in = 4'b1010; axis_in = 4'b0101;
        rd(ADDR_LEGACY, d); chk(d, 8'hA5, "R13 legacy readback");
        chk(button_out, 4'b1010, "R13 button passthrough");
        axis_in = '0; button_in = '0;
    endtask

    task automatic t_saturate;
        logic [7:0] d;
        int v;
        set_cfg(8'h01);
        wr(ADDR_HWCFG, 8'h01);
        @(negedge clk); axis_in[0] = 1'b1;
        wr(ADDR_VAL_LO, 8'h00);
        repeat (TMO + 20) @(negedge clk);
        chk(irq, 1, "R7 timeout ends measurement");
        read_axis(0, v); chk(v, 65535, "R6 count saturates");
        axis_in[0] = 1'b0;
        rd(ADDR_CFG, d);
    endtask

    task automatic t_continuous;
        logic [7:0] d;
        int v;
        set_cfg(8'h41);
        repeat (10) @(negedge clk);
        read_axis(0, v); chk(v, 0, "R11 auto relatch without trigger");
        rd(ADDR_CFG, d);
        repeat (10) @(negedge clk);
        rd(ADDR_CFG, d); chk(d[7], 1, "R11 ready returns in continuous mode");
        set_cfg(8'h01);
        repeat (10) @(negedge clk);
        rd(ADDR_CFG, d);
        repeat (20) @(negedge clk);
        rd(ADDR_CFG, d); chk(d[7], 0, "R11 no restart when latch clear");
        axis_in[0] = 1'b1;
        repeat (20) @(negedge clk);
        axis_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        read_axis(0, v); chk(v, 0, "R11 latch frozen without trigger");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four_axes();
        t_half_disabled();
        t_slow_rates();
        t_hw_legacy();
        t_saturate();
        t_continuous();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule